// File: doc/BRIEF.md
# Prioritized Local Interrupt Cause Selector

This block keeps a pending-interrupt register and an enable register for a processor hart. Each clock it picks the one interrupt that should be taken. Each cause code from 0 to 63 has a pending bit, an enable bit and a bit in an externally supplied global mask. A cause can be selected only when all three of its bits are set.

Pending bits are set by strobes and by rising edges on a vector of local interrupt pins. They are cleared by per-cause clear strobes or by a clear-all strobe. A separate non-maskable request sits above everything else.

Local interrupts (cause 16 and up) outrank all nine standard causes. Among local interrupts, the higher cause number wins. A mode input limits the local range: 16 to 31 in 32-bit mode, and 16 to 63 in 64-bit mode. The result is registered and presented as a valid flag, a non-maskable flag and a 6-bit cause code.

Top module: `irq_cause_sel`

## Requirements
- R1: A pending non-maskable request wins over every other cause. In that case, valid_o=1, nmi_o=1 and cause_o=0.
- R2: A cause is a candidate only when its pending bit, its enable bit and its mask_i bit are all 1.
- R3: Any candidate local cause (16..63) outranks every standard cause.
- R4: Among local candidates, the one with the highest cause number is selected.
- R5: Standard causes rank, from highest to lowest: 11, 3, 7, 9, 1, 5, 8, 0, 4.
- R6: When xlen64_i=0, local causes 32..63 are never selected. When xlen64_i=1, causes 16..63 are eligible.
- R7: A rising edge on local_pin_i[n] sets the pending bit of cause n+16.
- R8: A set_i bit sets that cause's pending bit and a clr_i bit clears it. clr_all_i clears every pending bit and the non-maskable flag. nmi_set_i sets the non-maskable flag. A 1 on ie_we_i loads ie_wdata_i into the enable register.
- R9: In the same cycle, a set (strobe, pin edge or nmi_set_i) takes precedence over clr_i and over clr_all_i.
- R10: Outputs are registered. A mask_i change shows one clock later. A pending or enable write shows two clocks after the strobe is sampled.
- R11: When nothing is selected, valid_o=0, nmi_o=0 and cause_o=0.
- R12: Cause codes 2, 6, 10 and 12..15 have no pending bit. Setting them has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_i | input | 64 | Per-cause pending set strobes |
| clr_i | input | 64 | Per-cause pending clear strobes |
| clr_all_i | input | 1 | Clear all pending bits and the non-maskable flag |
| nmi_set_i | input | 1 | Post the non-maskable request |
| local_pin_i | input | 48 | Local interrupt pins; pin n maps to cause n+16 |
| ie_we_i | input | 1 | Enable register write strobe |
| ie_wdata_i | input | 64 | Enable register write data |
| mask_i | input | 64 | Global per-cause mask |
| xlen64_i | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| valid_o | output | 1 | An interrupt is selected |
| nmi_o | output | 1 | The selection is the non-maskable request |
| cause_o | output | 6 | Selected cause code |

## Verification
Some properties are checked on every cycle against the previous cycle's candidate set:
- the non-maskable request wins;
- the selected cause is a candidate;
- no standard cause is chosen while a local one is eligible;
- no higher local candidate is skipped;
- 32-bit mode never yields a cause above 31;
- the idle output is all zero;
- pin edges and set-over-clear land in the pending register.

Other behaviour only shows in the bench's scenarios:
- the full order of the standard causes;
- the exact two-cycle latency of writes;
- that unimplemented cause codes stay silent.

The bench covers these with directed sequences, and with random traffic compared against a reference model.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int CAUSE_W  = 6;
  localparam int N_STD    = 9;
  localparam logic [15:0] STD_IMPL = 16'h0BBB;

  typedef logic [CAUSE_W-1:0] cause_t;

  typedef struct packed {
    logic   valid;
    logic   nmi;
    cause_t cause;
  } pick_t;

  // standard causes, highest priority first
  localparam cause_t STD_ORDER [N_STD] = '{
    6'd11, 6'd3, 6'd7, 6'd9, 6'd1, 6'd5, 6'd8, 6'd0, 6'd4
  };
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_sel_pkg::*;
#(
  parameter int N_CAUSE  = 64,
  parameter int LOC_BASE = 16,
  localparam int N_PIN   = N_CAUSE - LOC_BASE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] set_i,
  input  logic [N_CAUSE-1:0] clr_i,
  input  logic               clr_all_i,
  input  logic               nmi_set_i,
  input  logic [N_PIN-1:0]   pin_i,
  output logic [N_CAUSE-1:0] pend_o,
  output logic               nmi_o
);
  logic [N_PIN-1:0]   pin_q;
  logic [N_CAUSE-1:0] set_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  assign set_all = set_i | {(pin_i & ~pin_q), {LOC_BASE{1'b0}}};

  for (genvar b = 0; b < N_CAUSE; b++) begin : g_bit
    if (b >= LOC_BASE || STD_IMPL[b % 16]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         pend_o[b] <= 1'b0;
        else if (set_all[b]) pend_o[b] <= 1'b1;
        else if (clr_i[b] || clr_all_i) pend_o[b] <= 1'b0;
      end
    end else begin : g_none
      assign pend_o[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        nmi_o <= 1'b0;
    else if (nmi_set_i) nmi_o <= 1'b1;
    else if (clr_all_i) nmi_o <= 1'b0;
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int N_CAUSE = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [N_CAUSE-1:0] wdata_i,
  output logic [N_CAUSE-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (we_i) en_o <= wdata_i;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_sel_pkg::*;
#(
  parameter int N_CAUSE  = 64,
  parameter int LOC_BASE = 16,
  parameter int RV32_TOP = 32
) (
  input  logic [N_CAUSE-1:0] cand_i,
  input  logic               nmi_i,
  input  logic               xlen64_i,
  output pick_t              pick_o
);
  always_comb begin
    pick_o = '0;
    // lowest priority first; later hits overwrite
    for (int i = N_STD - 1; i >= 0; i--) begin
      if (cand_i[STD_ORDER[i]]) begin
        pick_o.valid = 1'b1;
        pick_o.cause = STD_ORDER[i];
      end
    end
    for (int i = LOC_BASE; i < N_CAUSE; i++) begin
      if (cand_i[i] && (xlen64_i || i < RV32_TOP)) begin
        pick_o.valid = 1'b1;
        pick_o.cause = CAUSE_W'(i);
      end
    end
    if (nmi_i) begin
      pick_o.valid = 1'b1;
      pick_o.nmi   = 1'b1;
      pick_o.cause = '0;
    end
  end
endmodule

// File: rtl/irq_cause_sel.sv
module irq_cause_sel
  import irq_sel_pkg::*;
#(
  parameter int N_CAUSE  = 64,
  parameter int LOC_BASE = 16,
  parameter int RV32_TOP = 32,
  localparam int N_PIN   = N_CAUSE - LOC_BASE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] set_i,
  input  logic [N_CAUSE-1:0] clr_i,
  input  logic               clr_all_i,
  input  logic               nmi_set_i,
  input  logic [N_PIN-1:0]   local_pin_i,
  input  logic               ie_we_i,
  input  logic [N_CAUSE-1:0] ie_wdata_i,
  input  logic [N_CAUSE-1:0] mask_i,
  input  logic               xlen64_i,
  output logic               valid_o,
  output logic               nmi_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [N_CAUSE-1:0] pend, ie_q, cand;
  logic               nmi_pend;
  pick_t              pick, pick_q;

  irq_pend_reg #(.N_CAUSE(N_CAUSE), .LOC_BASE(LOC_BASE)) i_pend (
    .clk_i, .rst_ni, .set_i, .clr_i, .clr_all_i, .nmi_set_i,
    .pin_i (local_pin_i),
    .pend_o(pend),
    .nmi_o (nmi_pend)
  );

  irq_en_reg #(.N_CAUSE(N_CAUSE)) i_en (
    .clk_i, .rst_ni,
    .we_i   (ie_we_i),
    .wdata_i(ie_wdata_i),
    .en_o   (ie_q)
  );

  assign cand = pend & ie_q & mask_i;

  irq_pick #(.N_CAUSE(N_CAUSE), .LOC_BASE(LOC_BASE), .RV32_TOP(RV32_TOP)) i_pick (
    .cand_i  (cand),
    .nmi_i   (nmi_pend),
    .xlen64_i(xlen64_i),
    .pick_o  (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pick_q <= '0;
    else         pick_q <= pick;
  end

  assign valid_o = pick_q.valid;
  assign nmi_o   = pick_q.nmi;
  assign cause_o = pick_q.cause;
endmodule

// File: rtl/irq_cause_sel_chk.sv
module irq_cause_sel_chk #(
  parameter int N_CAUSE  = 64,
  parameter int LOC_BASE = 16,
  parameter int RV32_TOP = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CAUSE-1:0] pend,
  input logic [N_CAUSE-1:0] ie_q,
  input logic               nmi_pend,
  input logic [N_CAUSE-1:0] mask_i,
  input logic               xlen64_i,
  input logic [N_CAUSE-LOC_BASE-1:0] local_pin_i,
  input logic [N_CAUSE-1:0] set_i,
  input logic [N_CAUSE-1:0] clr_i,
  input logic               valid_o,
  input logic               nmi_o,
  input logic [5:0]         cause_o
);
  localparam int N_LOC = N_CAUSE - LOC_BASE;
  logic [N_CAUSE-1:0] cand_q;
  logic [N_LOC-1:0]   loc_q, range_m;

  for (genvar k = 0; k < N_LOC; k++) begin : g_rng
    assign range_m[k] = (k + LOC_BASE < RV32_TOP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      loc_q  <= '0;
    end else begin
      cand_q <= pend & ie_q & mask_i;
      loc_q  <= (pend[N_CAUSE-1:LOC_BASE] & ie_q[N_CAUSE-1:LOC_BASE] & mask_i[N_CAUSE-1:LOC_BASE])
                & (xlen64_i ? '1 : range_m);
    end
  end

  AST_NMI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pend |=> (nmi_o && valid_o && cause_o == 6'd0)); // R1
  AST_CAUSE_IS_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !nmi_o) |-> cand_q[cause_o]); // R2
  AST_LOCAL_ABOVE_STD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !nmi_o && cause_o < 6'(LOC_BASE)) |-> (loc_q == '0)); // R3
  AST_HIGHEST_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !nmi_o && cause_o >= 6'(LOC_BASE))
      |-> ((loc_q >> (cause_o - 6'(LOC_BASE) + 6'd1)) == '0)); // R4
  AST_RV32_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !nmi_o && !$past(xlen64_i)) |-> (cause_o < 6'(RV32_TOP))); // R6
  AST_PIN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(local_pin_i[0]) |=> pend[LOC_BASE]); // R7
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i[11] && clr_i[11]) |=> pend[11]); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cause_o == 6'd0 && !nmi_o)); // R11
endmodule

bind irq_cause_sel irq_cause_sel_chk #(.N_CAUSE(N_CAUSE), .LOC_BASE(LOC_BASE), .RV32_TOP(RV32_TOP)) i_chk (
  .clk_i, .rst_ni, .pend, .ie_q, .nmi_pend, .mask_i, .xlen64_i, .local_pin_i,
  .set_i, .clr_i, .valid_o, .nmi_o, .cause_o
);

// File: tb/test_irq_cause_sel.sv
module test_irq_cause_sel;
  localparam logic [63:0] IMPL = 64'hFFFF_FFFF_FFFF_0BBB;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [63:0] set_i = '0, clr_i = '0, ie_wdata_i = '0, mask_i = '0;
  logic        clr_all_i = 1'b0, nmi_set_i = 1'b0, ie_we_i = 1'b0, xlen64_i = 1'b1;
  logic [47:0] local_pin_i = '0;
  logic        valid_o, nmi_o;
  logic [5:0]  cause_o;

  int n_run = 0, n_fail = 0;
  logic [5:0] ord [57];

  logic [63:0] pend_m, ie_m;
  logic [47:0] pin_m;
  logic        nmi_m, ev, en;
  logic [5:0]  ec;

  always #5 clk_i = ~clk_i;

  irq_cause_sel i_irq_cause_sel (
    .clk_i, .rst_ni, .set_i, .clr_i, .clr_all_i, .nmi_set_i, .local_pin_i,
    .ie_we_i, .ie_wdata_i, .mask_i, .xlen64_i, .valid_o, .nmi_o, .cause_o
  );

  function automatic logic [7:0] ref_pick(input logic [63:0] c, input logic nm, input logic x64);
    if (nm) return {2'b11, 6'd0};
    for (int k = 0; k < 57; k++) begin
      if (ord[k] >= 6'd32 && !x64) continue;
      if (c[ord[k]]) return {2'b10, ord[k]};
    end
    return 8'd0;
  endfunction

  // reference model: outputs from pre-edge state, then state update
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_m = '0; ie_m = '0; pin_m = '0; nmi_m = 1'b0; ev = 0; en = 0; ec = 0;
    end else begin
      {ev, en, ec} = ref_pick(pend_m & ie_m & mask_i, nmi_m, xlen64_i);
      pend_m = ((pend_m & ~clr_i & ~{64{clr_all_i}}) | set_i
                | {(local_pin_i & ~pin_m), 16'h0}) & IMPL;
      nmi_m  = nmi_set_i | (nmi_m & ~clr_all_i);
      if (ie_we_i) ie_m = ie_wdata_i;
      pin_m  = local_pin_i;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic v, input logic nm, input logic [5:0] c);
    n_run++;
    if (valid_o !== v || nmi_o !== nm || cause_o !== c) begin
      n_fail++;
      $display("FAIL %s: got v=%0b n=%0b c=%0d, exp v=%0b n=%0b c=%0d",
               tag, valid_o, nmi_o, cause_o, v, nm, c);
    end
  endtask

  task automatic pulse_set(input logic [63:0] s);
    set_i = s; tick(1); set_i = '0; tick(1);
  endtask

  task automatic pulse_clr(input logic [63:0] s);
    clr_i = s; tick(1); clr_i = '0; tick(1);
  endtask

  task automatic write_ie(input logic [63:0] d);
    ie_we_i = 1'b1; ie_wdata_i = d; tick(1); ie_we_i = 1'b0; tick(1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 48; k++) ord[k] = 6'(63 - k);
    ord[48] = 6'd11; ord[49] = 6'd3; ord[50] = 6'd7; ord[51] = 6'd9; ord[52] = 6'd1;
    ord[53] = 6'd5;  ord[54] = 6'd8; ord[55] = 6'd0; ord[56] = 6'd4;
    void'($urandom(32'd1234));

    tick(3);
    rst_ni = 1'b1;
    tick(1);
    chk("R11 reset", 0, 0, 0);

    mask_i = '1;
    write_ie('1);
    set_i = 64'h80; tick(1); set_i = '0;
    chk("R10 one-cycle lag", 0, 0, 0);
    tick(1);
    chk("R8 set cause 7", 1, 0, 7);
    pulse_set(64'h8);    chk("R5 3 over 7", 1, 0, 3);
    pulse_set(64'h200);  chk("R5 3 over 9", 1, 0, 3);
    pulse_set(64'h800);  chk("R5 11 on top", 1, 0, 11);

    local_pin_i[0] = 1'b1; tick(2);
    chk("R7 R3 pin0 -> 16", 1, 0, 16);
    local_pin_i[5] = 1'b1; tick(2);
    chk("R4 pin5 -> 21", 1, 0, 21);
    pulse_set(64'h1 << 40); chk("R4 cause 40", 1, 0, 40);
    xlen64_i = 1'b0; tick(1);
    chk("R6 rv32 hides 40", 1, 0, 21);

    write_ie(~(64'h1 << 21)); chk("R2 enable off 21", 1, 0, 16);
    mask_i[16] = 1'b0; tick(1);
    chk("R2 mask off 16", 1, 0, 11);
    mask_i = '1; write_ie('1);
    chk("R10 restored", 1, 0, 21);
    pulse_clr(64'h1 << 21); chk("R8 clear 21", 1, 0, 16);
    pulse_clr(64'h1 << 16); chk("R8 clear 16", 1, 0, 11);
    set_i = 64'h1 << 16; clr_i = 64'h1 << 16; tick(1);
    set_i = '0; clr_i = '0; tick(1);
    chk("R9 set beats clear", 1, 0, 16);

    nmi_set_i = 1'b1; tick(1); nmi_set_i = 1'b0; tick(1);
    chk("R1 nmi wins", 1, 1, 0);
    clr_all_i = 1'b1; tick(1); clr_all_i = 1'b0; tick(1);
    chk("R8 clear all", 0, 0, 0);
    pulse_set(64'hF444); chk("R12 unimplemented", 0, 0, 0);

    local_pin_i[0] = 1'b0; tick(1);
    local_pin_i[0] = 1'b1; clr_all_i = 1'b1; tick(1); clr_all_i = 1'b0; tick(1);
    chk("R9 pin edge beats clear-all", 1, 0, 16);

    xlen64_i = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      set_i       = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      clr_i       = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      clr_all_i   = ($urandom % 40) == 0;
      nmi_set_i   = ($urandom % 60) == 0;
      ie_we_i     = ($urandom % 10) == 0;
      ie_wdata_i  = {$urandom, $urandom} | {$urandom, $urandom};
      mask_i      = {$urandom, $urandom} | {$urandom, $urandom};
      if (($urandom % 20) == 0) xlen64_i = ~xlen64_i;
      local_pin_i = local_pin_i ^ ({$urandom, $urandom} & {$urandom, $urandom}
                                   & {$urandom, $urandom});
      tick(1);
      chk("R10 random vs model", ev, en, ec);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule